// File: doc/BRIEF.md
# Chained Multiply-Add Processing Row

This block is one row of a coarse-grained arithmetic array. Three 32-bit processing stages sit in a fixed cascade; each stage owns a multiplier and an adder that can add, subtract or accumulate. A configuration word picks one operation per stage and a chain length of one, two or three. The row output is taken from whichever stage ends the chain. That lets the same wiring serve a multiply-accumulate, a butterfly-like add/subtract pair or a cascade of multiplies. The row accepts one element per cycle.

Every stage reads its own local operand words, and those words come from memories wired to that stage alone. Stage 1 combines two local words (`in_a`, stage-1 slice of `in_b`). A later stage combines the previous stage's result with its own slice of `in_b`. The multiply-add operation also uses that stage's slice of `in_c`. The caller presents all slices of one element in the same cycle, and the row delays each stage's slices internally to line them up with the data in flight.

The input stream has a valid strobe but no ready: the row never stalls, and the result stream cannot be held back either, so there is no back-pressure in either direction. The consumer, normally a result memory, must take every `res_we` pulse. The configuration must stay constant while any element is in flight.

Top module: `chain_row`

## Requirements
- R1: While reset is asserted and after its release, `res_valid` and `res_we` are 0 and `res_data` is 0 until the first result leaves the row.
- R2: Stage opcodes are 3-bit fields: 000 pass x, 001 x*b, 010 x+b, 011 x-b, 100 accumulate x*b, 101 x*b+c. All arithmetic wraps modulo 2^32, and a product keeps only its low 32 bits.
- R3: Stage k of the row takes its opcode from `cfg_ops[3k+2:3k]` (k=0 first) and its local words from `in_b[32k+31:32k]` and `in_c[32k+31:32k]`. Stage 0 uses `in_a` as x; stage k>0 uses the result of stage k-1 as x.
- R4: `cfg_len` selects the chain length: 1, 2 or 3 stages. The value 0 acts as 1. The output is taken from the last stage of the chain.
- R5: `res_valid` rises exactly L cycles after the cycle in which `in_valid` was sampled high, where L is the chain length. A new element may enter on every cycle.
- R6: When no active stage (index below L) is set to accumulate, `res_we` equals `res_valid`.
- R7: An accumulating stage starts from zero for the first element after reset and for the first element after an element marked `in_last`. When an active stage accumulates, `res_we` pulses only for the element marked `in_last`; `res_valid` and `res_data` still show each partial result.
- R8: Opcodes 110 and 111 behave as pass.
- R9: In a cycle without a result, `res_data` keeps the value of the last result from the same tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 2 | Chain length, 0 and 1 both mean one stage |
| cfg_ops | input | 9 | Three 3-bit stage opcodes, stage 0 in the low bits |
| in_valid | input | 1 | An element is presented this cycle |
| in_last | input | 1 | Presented element closes an accumulation run |
| in_a | input | 32 | Stage 0 first operand |
| in_b | input | 96 | Multiplier/adder operand for each stage |
| in_c | input | 96 | Addend for multiply-add, one per stage |
| res_data | output | 32 | Result from the tap stage |
| res_valid | output | 1 | Tap stage holds a new result |
| res_we | output | 1 | Write strobe for the result memory |

## Verification
Wrapping is probed with an all-ones sum, a product that overflows to zero and a subtraction below zero. An implementation that saturates or keeps high product bits would produce a different word. Length 0 is driven to catch a tap that selects nothing or the wrong stage. Each length is checked for the exact cycle of `res_valid`, which exposes a missing or extra pipeline register. Two back-to-back accumulation runs separated by `in_last` show whether the accumulator restarts at zero: a design that forgets to clear would carry the first sum into the second, and one that writes every partial sum would pulse `res_we` too often. Idle gaps after bursts catch an output that changes without a new result. Opcodes 110 and 111 are driven to catch an implementation that does not treat them as pass.

// File: rtl/chain_row_pkg.sv
package chain_row_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_PASS   = 3'b000;
  localparam logic [OPW-1:0] OP_MUL    = 3'b001;
  localparam logic [OPW-1:0] OP_ADD    = 3'b010;
  localparam logic [OPW-1:0] OP_SUB    = 3'b011;
  localparam logic [OPW-1:0] OP_ACC    = 3'b100;
  localparam logic [OPW-1:0] OP_MULADD = 3'b101;
endpackage

// File: rtl/chain_delay.sv
module chain_delay #(
  parameter int W = 32,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [D];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[D-1];
endmodule

// File: rtl/chain_pe.sv
module chain_pe
  import chain_row_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  input  logic           x_vld,
  input  logic           x_last,
  input  logic [W-1:0]   x_data,
  input  logic [W-1:0]   b_data,
  input  logic [W-1:0]   c_data,
  output logic           y_vld,
  output logic           y_last,
  output logic [W-1:0]   y_data
);
  logic         fresh;
  logic [W-1:0] prod;
  logic [W-1:0] acc_base;
  logic [W-1:0] nxt;

  assign prod     = x_data * b_data;
  assign acc_base = fresh ? '0 : y_data;

  always_comb begin
    case (op)
      OP_MUL:    nxt = prod;
      OP_ADD:    nxt = x_data + b_data;
      OP_SUB:    nxt = x_data - b_data;
      OP_ACC:    nxt = acc_base + prod;
      OP_MULADD: nxt = prod + c_data;
      default:   nxt = x_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_vld  <= 1'b0;
      y_last <= 1'b0;
      y_data <= '0;
      fresh  <= 1'b1;
    end else begin
      y_vld <= x_vld;
      if (x_vld) begin
        y_data <= nxt;
        y_last <= x_last;
        fresh  <= x_last;
      end
    end
  end

  // R5: one register of latency per stage
  a_r5_stage_follow: assert property (@(posedge clk) disable iff (!rst_n)
    x_vld |=> y_vld);
  a_r5_stage_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !x_vld |=> !y_vld);
  // R9: stage output holds without new input
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !x_vld |=> $stable(y_data));
endmodule

// File: rtl/chain_row.sv
module chain_row
  import chain_row_pkg::*;
#(
  parameter int W      = 32,
  parameter int NSTAGE = 3,
  localparam int LENW  = $clog2(NSTAGE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LENW-1:0]       cfg_len,
  input  logic [NSTAGE*OPW-1:0] cfg_ops,
  input  logic                  in_valid,
  input  logic                  in_last,
  input  logic [W-1:0]          in_a,
  input  logic [NSTAGE*W-1:0]   in_b,
  input  logic [NSTAGE*W-1:0]   in_c,
  output logic [W-1:0]          res_data,
  output logic                  res_valid,
  output logic                  res_we
);
  logic           st_vld  [NSTAGE];
  logic           st_last [NSTAGE];
  logic [W-1:0]   st_data [NSTAGE];
  logic [LENW-1:0] len_eff;
  logic [LENW-1:0] tap;
  logic            acc_in_chain;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic [W-1:0] b_al, c_al, x_d;
    logic         x_v, x_l;
    if (k == 0) begin : g_head
      assign b_al = in_b[W-1:0];
      assign c_al = in_c[W-1:0];
      assign x_d  = in_a;
      assign x_v  = in_valid;
      assign x_l  = in_last;
    end else begin : g_tail
      chain_delay #(.W(W), .D(k)) u_bdly (
        .clk(clk), .rst_n(rst_n), .d(in_b[k*W +: W]), .q(b_al));
      chain_delay #(.W(W), .D(k)) u_cdly (
        .clk(clk), .rst_n(rst_n), .d(in_c[k*W +: W]), .q(c_al));
      assign x_d = st_data[k-1];
      assign x_v = st_vld[k-1];
      assign x_l = st_last[k-1];
    end
    chain_pe #(.W(W)) u_pe (
      .clk(clk), .rst_n(rst_n), .op(cfg_ops[k*OPW +: OPW]),
      .x_vld(x_v), .x_last(x_l), .x_data(x_d), .b_data(b_al), .c_data(c_al),
      .y_vld(st_vld[k]), .y_last(st_last[k]), .y_data(st_data[k]));
  end

  always_comb begin
    if (cfg_len == '0)                     len_eff = LENW'(1);
    else if (int'(cfg_len) > NSTAGE)       len_eff = LENW'(NSTAGE);
    else                                   len_eff = cfg_len;
    tap = len_eff - LENW'(1);
    acc_in_chain = 1'b0;
    for (int k = 0; k < NSTAGE; k++)
      if (k < int'(len_eff) && cfg_ops[k*OPW +: OPW] == OP_ACC)
        acc_in_chain = 1'b1;
  end

  assign res_valid = st_vld[tap];
  assign res_data  = st_data[tap];
  assign res_we    = res_valid & (~acc_in_chain | st_last[tap]);

  // cycles since reset, saturating, for the latency check
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  // R5: result valid lands exactly chain-length cycles after input valid
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && cfg_len == $past(cfg_len) && cfg_len == $past(cfg_len, 2)
     && cfg_len == $past(cfg_len, 3))
    |-> res_valid == ((cfg_len <= LENW'(1)) ? $past(in_valid) :
                      (cfg_len == LENW'(2)) ? $past(in_valid, 2) : $past(in_valid, 3)));
  // R6/R7: a write never happens without a result
  a_r6_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_valid);
endmodule

// File: tb/chain_row_test.sv
`timescale 1ns/1ps
module chain_row_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_len = 2'd1;
  logic [8:0]  cfg_ops = '0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_a = '0;
  logic [95:0] in_b = '0, in_c = '0;
  logic [31:0] res_data;
  logic        res_valid, res_we;

  always #10 clk = ~clk;

  chain_row uut (.clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ops(cfg_ops),
    .in_valid(in_valid), .in_last(in_last), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .res_data(res_data), .res_valid(res_valid), .res_we(res_we));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit          ex_v [16];
  bit          ex_w [16];
  logic [31:0] ex_d [16];
  string       ex_t [16];
  int          k = 0;
  logic [31:0] my [3];
  bit          mfresh [3];
  logic [31:0] last_d = '0;
  bit          hold_en = 0;
  string       tag = "R2";

  function automatic logic [31:0] alu(input logic [2:0] op, input logic [31:0] x,
                                      input logic [31:0] b, input logic [31:0] c,
                                      input logic [31:0] acc);
    logic [31:0] p;
    p = x * b;
    case (op)
      3'b001: return p;
      3'b010: return x + b;
      3'b011: return x - b;
      3'b100: return acc + p;
      3'b101: return p + c;
      default: return x;
    endcase
  endfunction

  function automatic int len_of(input logic [1:0] l);
    return (l == 2'd0) ? 1 : int'(l);
  endfunction

  task automatic cmp(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", t, act, exp, $time);
    end
  endtask

  task automatic tick(input bit v, input bit lst, input logic [31:0] a,
                      input logic [95:0] bb, input logic [95:0] cc);
    int s, L;
    logic [31:0] x, y;
    bit acc_on;
    @(negedge clk);
    s = k % 16;
    cmp("R5 res_valid", {31'd0, res_valid}, {31'd0, ex_v[s]});
    cmp(ex_t[s] == "R7" ? "R7 res_we" : "R6 res_we", {31'd0, res_we}, {31'd0, ex_w[s]});
    if (ex_v[s]) begin
      cmp(ex_t[s], res_data, ex_d[s]);
      last_d = ex_d[s];
      hold_en = 1;
    end else if (hold_en) begin
      cmp("R9 hold", res_data, last_d);
    end
    ex_v[s] = 0; ex_w[s] = 0; ex_d[s] = '0; ex_t[s] = "R5";
    in_valid = v; in_last = lst; in_a = a; in_b = bb; in_c = cc;
    if (v) begin
      L = len_of(cfg_len);
      x = a;
      acc_on = 0;
      for (int j = 0; j < 3; j++) begin
        y = alu(cfg_ops[j*3 +: 3], x, bb[j*32 +: 32], cc[j*32 +: 32],
                mfresh[j] ? 32'd0 : my[j]);
        my[j] = y; mfresh[j] = lst;
        if (j < L && cfg_ops[j*3 +: 3] == 3'b100) acc_on = 1;
        if (j == L - 1) begin
          s = (k + L) % 16;
          ex_v[s] = 1; ex_d[s] = y; ex_w[s] = acc_on ? lst : 1'b1;
          ex_t[s] = acc_on ? "R7" : tag;
        end
        x = y;
      end
    end
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, '0, '0, '0);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [8:0] ops);
    idle(4);
    cfg_len = l; cfg_ops = ops; hold_en = 0;
  endtask

  function automatic logic [95:0] w3(input logic [31:0] w0, input logic [31:0] w1,
                                     input logic [31:0] w2);
    return {w2, w1, w0};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin ex_v[i] = 0; ex_w[i] = 0; ex_d[i] = '0; ex_t[i] = "R5"; end
    for (int j = 0; j < 3; j++) begin my[j] = '0; mfresh[j] = 1; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    cmp("R1 res_valid", {31'd0, res_valid}, 32'd0);
    cmp("R1 res_we", {31'd0, res_we}, 32'd0);
    cmp("R1 res_data", res_data, 32'd0);
    rst_n = 1'b1;
    k = 0;
    idle(2);

    // R2: single stage, each opcode with wrap-around
    tag = "R2";
    set_cfg(2'd1, 9'b000_000_010);
    tick(1, 0, 32'hFFFF_FFFF, w3(32'd2, 0, 0), '0);
    set_cfg(2'd1, 9'b000_000_001);
    tick(1, 0, 32'h0001_0000, w3(32'h0001_0000, 0, 0), '0);
    tick(1, 0, 32'h1234_5678, w3(32'h9ABC_DEF1, 0, 0), '0);
    set_cfg(2'd1, 9'b000_000_011);
    tick(1, 0, 32'd0, w3(32'd1, 0, 0), '0);
    set_cfg(2'd1, 9'b000_000_101);
    tick(1, 0, 32'd3, w3(32'd5, 0, 0), w3(32'd7, 0, 0));
    set_cfg(2'd1, 9'b000_000_000);
    tick(1, 0, 32'hCAFE_F00D, w3(32'd9, 0, 0), '0);
    idle(3);

    // R4: length 0 behaves as one stage
    tag = "R4";
    set_cfg(2'd0, 9'b001_001_010);
    tick(1, 0, 32'd40, w3(32'd2, 32'd100, 32'd100), '0);
    tick(1, 0, 32'd1, w3(32'd1, 32'd100, 32'd100), '0);
    idle(3);

    // R3: full three-stage chain, back to back elements
    tag = "R3";
    set_cfg(2'd3, 9'b011_010_001);
    for (int i = 0; i < 5; i++)
      tick(1, 0, 32'(i + 3), w3(32'(i + 2), 32'(10 * i), 32'd7), '0);
    idle(4);
    set_cfg(2'd2, 9'b000_101_011);
    for (int i = 0; i < 4; i++)
      tick(1, 0, 32'(100 + i), w3(32'd1, 32'(i + 1), 0), w3(0, 32'd50, 0));
    idle(4);

    // R7: accumulation in stage 2, two runs
    set_cfg(2'd2, 9'b000_100_000);
    for (int i = 0; i < 4; i++) tick(1, i == 3, 32'(i + 1), w3(0, 32'd3, 0), '0);
    for (int i = 0; i < 3; i++) tick(1, i == 2, 32'(10 + i), w3(0, 32'd2, 0), '0);
    idle(4);
    // R7: accumulation in stage 1 with gaps
    set_cfg(2'd1, 9'b000_000_100);
    tick(1, 0, 32'hFFFF_FFFF, w3(32'd2, 0, 0), '0);
    tick(0, 0, '0, '0, '0);
    tick(1, 1, 32'd5, w3(32'd5, 0, 0), '0);
    tick(1, 1, 32'd6, w3(32'd6, 0, 0), '0);
    idle(4);

    // R8: reserved opcodes act as pass
    tag = "R8";
    set_cfg(2'd2, 9'b000_111_110);
    tick(1, 0, 32'hDEAD_BEEF, w3(32'd3, 32'd4, 0), w3(32'd1, 32'd1, 0));
    tick(1, 0, 32'h0000_0077, w3(32'd3, 32'd4, 0), '0);
    idle(5);   // R9: hold checked in these idle cycles

    // R3/R6: random configurations and streams
    tag = "R3";
    for (int c = 0; c < 40; c++) begin
      set_cfg(2'($urandom % 4), 9'($urandom));
      for (int i = 0; i < 25; i++) begin
        logic [31:0] a;
        a = ($urandom % 4 == 0) ? ($urandom % 16) : $urandom;
        tick(($urandom % 4) != 0, ($urandom % 5) == 0, a,
             w3($urandom, $urandom % 64, $urandom),
             w3($urandom, $urandom, $urandom));
      end
      idle(4);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule